// File: doc/BRIEF.md
# Loopback Serial Port Register Model

This block presents the eight byte-wide registers of a 16550-style serial port on a plain register bus, with no serial line behind them. A byte written to the data register is pushed into an internal circular queue and comes back out when software reads the same address. Driver code written for that port can therefore be exercised end to end on a single chip, with nothing attached to any pin.

The divisor-latch bit in the line-control register switches addresses 0 and 1 over to the 16-bit divisor. The model also keeps the interrupt-enable, interrupt-cause, FIFO-control, line-control, modem-control, line-status, modem-status and scratch registers. Each access that meets one of the modelled interrupt conditions produces a one-cycle interrupt request.

Reads take effect within one cycle: `rdata` is valid while `rd_en` is high, and any side effect of the read (a pop, an interrupt) lands at the following clock edge.

Top module: `lbu_loopback`

## Requirements
- R1: Reset leaves the queue empty, the overrun flag clear and the maximum queue size at 16. All control registers read zero, the line status reads 0x60, the interrupt cause reads 0xC1 and the modem status reads 0xB3. The interrupt request output is low.
- R2: With the divisor-latch bit (LCR bit 7) clear, a write to address 0 pushes its byte, and reads of address 0 return the pushed bytes in first-in first-out order. The read and write positions wrap around the 16 entries. A read of address 0 while the queue is empty returns 0x00.
- R3: A write to address 0 while the occupancy has reached the current maximum size drops the byte and sets the overrun flag. If IER bit 2 is set, the same write raises an interrupt. The next accepted push clears the overrun flag.
- R4: Writing LCR with bit 7 set clears the divisor. While bit 7 is set, address 0 reads the divisor low byte and address 1 reads the high byte. Writes to either address OR into that byte, without touching the queue or IER.
- R5: A write to address 2 sets the maximum queue size from its bit 0: 16 entries when the bit is 1, one entry when it is 0. If bit 1 or bit 2 of the written value is set, the write also empties the queue.
- R6: The receive trigger level is fixed at one byte. An accepted push that brings the occupancy to exactly one raises an interrupt when IER bit 0 is set.
- R7: A read of address 0 that leaves the queue empty, or that finds it already empty, raises an interrupt when IER bit 1 is set. A write to IER whose value has bit 1 set, made while the queue is empty, also raises an interrupt.
- R8: Address 1 reads back IER bits 3:0 with bits 7:4 as zero. Address 2 reads 0xC0 ORed with the codes of all present causes: 0x06 for overrun under IER bit 2, 0x04 for occupancy at or above the trigger level under IER bit 0, and 0x02 for an empty queue under IER bit 1. When no cause is present it reads 0xC1. The modem-control cause adds no bits.
- R9: Line status has bit 0 set when the queue is non-empty, bit 1 set while the overrun flag is set, and bits 5 and 6 set when the queue is empty. Writes to addresses 5 and 6 change nothing.
- R10: Modem status reads 0xB3. It reads 0xA2 instead when MCR bit 5 (automatic flow) is set and the occupancy has reached the current maximum size.
- R11: A write to MCR raises an interrupt when IER bit 3 is set and the written value has bit 3, bit 1 or bit 0 set.
- R12: The interrupt request is high for exactly the one cycle that follows a qualifying access. An access that meets several conditions gives one pulse. The request is never high without an access in the cycle before.
- R13: LCR, MCR and the scratch register at address 7 read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe; takes precedence over a read in the same cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions watch the following on every cycle:
- the occupancy bound;
- the occupancy step on a push;
- the emptying on a FIFO-control clear;
- the overrun flag following a dropped or an accepted byte;
- the divisor clearing;
- the zero upper nibble on enable reads;
- the rule that no interrupt appears without a preceding access.

The bench scenarios cover what needs a history:
- first-in first-out order across the wrap point;
- the change of maximum size;
- the exact value of each status code under given enable settings;
- which accesses pulse the interrupt and which do not.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  localparam logic [2:0] RA_DATA      = 3'd0;
  localparam logic [2:0] RA_IEN       = 3'd1;
  localparam logic [2:0] RA_CAUSE     = 3'd2;  // read: cause, write: FIFO control
  localparam logic [2:0] RA_LINE_CTL  = 3'd3;
  localparam logic [2:0] RA_MODEM_CTL = 3'd4;
  localparam logic [2:0] RA_LINE_STAT = 3'd5;
  localparam logic [2:0] RA_MODEM_ST  = 3'd6;
  localparam logic [2:0] RA_SCRATCH   = 3'd7;

  // OR of every present cause, low bit set when none, top two bits forced
  function automatic logic [7:0] cause_code(input logic [3:0] ien, input logic ovr,
                                            input logic at_trig, input logic empty);
    logic [7:0] c;
    c = 8'h00;
    if (ien[2] && ovr)     c = c | 8'h06;
    if (ien[0] && at_trig) c = c | 8'h04;
    if (ien[1] && empty)   c = c | 8'h02;
    if (c == 8'h00)        c = 8'h01;
    return c | 8'hC0;
  endfunction

  function automatic logic [7:0] line_code(input logic empty, input logic ovr);
    return {1'b0, empty, empty, 3'b000, ovr, ~empty};
  endfunction

  function automatic logic [7:0] modem_code(input logic auto_flow, input logic at_max);
    return (auto_flow && at_max) ? 8'hA2 : 8'hB3;
  endfunction

endpackage

// File: rtl/lbu_ring.sv
module lbu_ring #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] head_q, tail_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[head_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      count  <= '0;
    end else if (clear) begin
      head_q <= '0;
      tail_q <= '0;
      count  <= '0;
    end else begin
      if (push) head_q <= step(head_q);
      if (pop)  tail_q <= step(tail_q);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[tail_q];

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)) else $error("occupancy above depth");
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear) |=> count == $past(count) + CW'(1)) else $error("push step");
  p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0) else $error("clear did not empty");

endmodule

// File: rtl/lbu_regread.sv
module lbu_regread
  import lbu_pkg::*;
#(
  parameter int CW = 5,
  parameter int TRIG_LEVEL = 1
) (
  input  logic [2:0]    addr,
  input  logic          dlab,
  input  logic [15:0]   divisor,
  input  logic [3:0]    ien,
  input  logic [7:0]    lctl,
  input  logic [7:0]    mctl,
  input  logic [7:0]    scratch,
  input  logic [7:0]    front,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] max_size,
  input  logic          ovr,
  output logic [7:0]    rdata
);
  logic empty, at_max, at_trig;

  assign empty   = (count == '0);
  assign at_max  = (count >= max_size);
  assign at_trig = (count >= CW'(TRIG_LEVEL));

  always_comb begin
    unique case (addr)
      RA_DATA:      rdata = dlab ? divisor[7:0] : (empty ? 8'h00 : front);
      RA_IEN:       rdata = dlab ? divisor[15:8] : {4'h0, ien};
      RA_CAUSE:     rdata = cause_code(ien, ovr, at_trig, empty);
      RA_LINE_CTL:  rdata = lctl;
      RA_MODEM_CTL: rdata = mctl;
      RA_LINE_STAT: rdata = line_code(empty, ovr);
      RA_MODEM_ST:  rdata = modem_code(mctl[5], at_max);
      default:      rdata = scratch;
    endcase
  end

endmodule

// File: rtl/lbu_loopback.sv
module lbu_loopback
  import lbu_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG_LEVEL = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW-1:0] TRIG = CW'(TRIG_LEVEL);

  logic [3:0]  ien_q;
  logic [7:0]  lctl_q, mctl_q, scr_q;
  logic [15:0] div_q;
  logic        ovr_q, wide_q;
  logic [CW-1:0] count, max_size;
  logic [7:0]  front;

  logic dlab, empty, full, rd_side;
  logic wr_data, wr_ien, wr_fctl, wr_lctl, wr_mctl, wr_scr, rd_data;
  logic ev_push, ev_drop, ev_pop, ev_clear;
  logic fire_rx, fire_ovr, fire_rd_empty, fire_ien, fire_modem, irq_d;

  assign dlab     = lctl_q[7];
  assign max_size = wide_q ? CW'(FIFO_DEPTH) : CW'(1);
  assign empty    = (count == '0);
  assign full     = (count >= max_size);
  assign rd_side  = rd_en && !wr_en;

  assign wr_data = wr_en && addr == RA_DATA;
  assign wr_ien  = wr_en && addr == RA_IEN;
  assign wr_fctl = wr_en && addr == RA_CAUSE;
  assign wr_lctl = wr_en && addr == RA_LINE_CTL;
  assign wr_mctl = wr_en && addr == RA_MODEM_CTL;
  assign wr_scr  = wr_en && addr == RA_SCRATCH;
  assign rd_data = rd_side && addr == RA_DATA && !dlab;

  assign ev_push  = wr_data && !dlab && !full;
  assign ev_drop  = wr_data && !dlab && full;
  assign ev_pop   = rd_data && !empty;
  assign ev_clear = wr_fctl && (wdata[1] || wdata[2]);

  assign fire_rx       = ev_push && ien_q[0] && (count + CW'(1) == TRIG);
  assign fire_ovr      = ev_drop && ien_q[2];
  assign fire_rd_empty = rd_data && ien_q[1] && (count <= CW'(1));
  assign fire_ien      = wr_ien && !dlab && wdata[1] && empty;
  assign fire_modem    = wr_mctl && ien_q[3] && (wdata[3] || wdata[1] || wdata[0]);
  assign irq_d = fire_rx | fire_ovr | fire_rd_empty | fire_ien | fire_modem;

  lbu_ring #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .pop(ev_pop), .clear(ev_clear),
    .din(wdata), .dout(front), .count(count)
  );

  lbu_regread #(.CW(CW), .TRIG_LEVEL(TRIG_LEVEL)) u_read (
    .addr(addr), .dlab(dlab), .divisor(div_q), .ien(ien_q), .lctl(lctl_q),
    .mctl(mctl_q), .scratch(scr_q), .front(front), .count(count),
    .max_size(max_size), .ovr(ovr_q), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      lctl_q <= '0;
      mctl_q <= '0;
      scr_q  <= '0;
      div_q  <= '0;
      ovr_q  <= 1'b0;
      wide_q <= 1'b1;
      irq    <= 1'b0;
    end else begin
      irq <= irq_d;
      if (ev_push) ovr_q <= 1'b0;
      if (ev_drop) ovr_q <= 1'b1;
      if (wr_data && dlab) div_q[7:0] <= div_q[7:0] | wdata;
      if (wr_ien && dlab)  div_q[15:8] <= div_q[15:8] | wdata;
      if (wr_ien && !dlab) ien_q <= wdata[3:0];
      if (wr_fctl) wide_q <= wdata[0];
      if (wr_lctl) begin
        lctl_q <= wdata;
        if (wdata[7]) div_q <= '0;
      end
      if (wr_mctl) mctl_q <= wdata;
      if (wr_scr)  scr_q  <= wdata;
    end
  end

  p_drop_sets_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ovr_q) else $error("drop without overrun");
  p_push_clears_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> !ovr_q) else $error("overrun kept after push");
  p_div_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_LINE_CTL && wdata[7]) |=> div_q == 16'h0000) else $error("divisor not cleared");
  p_ien_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == RA_IEN && !dlab) |-> rdata[7:4] == 4'h0) else $error("enable read upper bits");
  p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_en || rd_en)) else $error("interrupt without access");

endmodule

// File: tb/lbu_loopback_test.sv
module lbu_loopback_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic irq_obs = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lbu_loopback uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: compares each read against the next scoreboard entry
  always @(negedge clk) begin
    #1;
    if (rd_en) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read addr %0d rdata=%02h expected none", addr, rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s addr %0d rdata=%02h expected %02h", t, addr, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; irq_obs = irq;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; irq_obs = irq;
  endtask

  task automatic idle();
    @(negedge clk);
    irq_obs = irq;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq_obs !== e) begin
      n_bad++;
      $display("FAIL %s irq=%0b expected %0b", t, irq_obs, e);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle(); chk_irq(1'b0, "R1");
    rd(3'd5, 8'h60, "R1 line status");
    rd(3'd2, 8'hC1, "R1 cause");
    rd(3'd6, 8'hB3, "R1 modem status");
    rd(3'd1, 8'h00, "R1 enable");
    rd(3'd0, 8'h00, "R2 empty read");

    // R13 plain registers
    wr(3'd7, 8'h5A); rd(3'd7, 8'h5A, "R13 scratch");
    wr(3'd3, 8'h03); rd(3'd3, 8'h03, "R13 line ctl");
    wr(3'd4, 8'h00);

    // R6 receive trigger, R12 pulse width
    wr(3'd1, 8'h01); chk_irq(1'b0, "R7 enable write without bit 1");
    wr(3'd0, 8'h11); chk_irq(1'b1, "R6 push to trigger");
    idle();          chk_irq(1'b0, "R12 pulse one cycle");
    wr(3'd0, 8'h22); chk_irq(1'b0, "R6 push past trigger");
    rd(3'd2, 8'hC4, "R8 cause at trigger");
    rd(3'd5, 8'h01, "R9 non-empty");
    rd(3'd0, 8'h11, "R2 order first");
    rd(3'd0, 8'h22, "R2 order second"); chk_irq(1'b0, "R7 empty read disabled");

    // R7 enable write, R8 nibble, R2 wrap, R3 overrun
    wr(3'd1, 8'h06); chk_irq(1'b1, "R7 enable write while empty");
    wr(3'd1, 8'hF6);
    rd(3'd1, 8'h06, "R8 enable nibble");
    rd(3'd2, 8'hC2, "R8 cause empty");
    for (int i = 0; i < 16; i++) wr(3'd0, 8'(i * 3 + 1));
    chk_irq(1'b0, "R6 no receive interrupt when disabled");
    wr(3'd0, 8'hEE); chk_irq(1'b1, "R3 drop interrupt");
    rd(3'd5, 8'h03, "R3 overrun in line status");
    rd(3'd2, 8'hC6, "R8 cause overrun");
    rd(3'd6, 8'hB3, "R10 no auto flow");
    wr(3'd4, 8'h20); chk_irq(1'b0, "R11 modem disabled");
    rd(3'd6, 8'hA2, "R10 auto flow full");
    wr(3'd5, 8'hFF); wr(3'd6, 8'h00);
    rd(3'd5, 8'h03, "R9 status writes ignored");
    rd(3'd0, 8'h01, "R2 wrap first");
    rd(3'd6, 8'hB3, "R10 auto flow with space");
    for (int i = 1; i < 16; i++) begin
      rd(3'd0, 8'(i * 3 + 1), "R2 wrap order");
      if (i == 14) chk_irq(1'b0, "R7 not yet empty");
    end
    chk_irq(1'b1, "R7 last pop");
    rd(3'd5, 8'h62, "R3 overrun held while empty");
    wr(3'd0, 8'h77);
    rd(3'd5, 8'h01, "R3 push clears overrun");
    rd(3'd0, 8'h77, "R2 after overrun");

    // R5 size and clear
    wr(3'd2, 8'h00); chk_irq(1'b0, "R5 control write");
    wr(3'd0, 8'h41);
    wr(3'd0, 8'h42); chk_irq(1'b1, "R5 single entry drop");
    rd(3'd6, 8'hA2, "R10 full at size one");
    rd(3'd0, 8'h41, "R5 single entry kept");
    rd(3'd0, 8'h00, "R2 empty read returns zero");
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h51); wr(3'd0, 8'h52); wr(3'd0, 8'h53);
    rd(3'd5, 8'h01, "R5 wide mode accepts three");
    wr(3'd2, 8'h02);
    rd(3'd5, 8'h60, "R5 clear empties");

    // R11 modem interrupts, R8 modem cause adds nothing
    wr(3'd1, 8'h08); chk_irq(1'b0, "R7 bit 1 clear");
    wr(3'd4, 8'h02); chk_irq(1'b1, "R11 request-to-send");
    wr(3'd4, 8'h20); chk_irq(1'b0, "R11 no qualifying bit");
    rd(3'd2, 8'hC1, "R8 no cause");
    wr(3'd4, 8'h01); chk_irq(1'b1, "R11 data-terminal-ready");
    rd(3'd2, 8'hC1, "R8 modem cause adds no bits");
    wr(3'd1, 8'h0A); chk_irq(1'b1, "R7 enable write empty");
    wr(3'd4, 8'h0B); chk_irq(1'b1, "R12 combined conditions");
    idle();          chk_irq(1'b0, "R12 single pulse");
    rd(3'd4, 8'h0B, "R13 modem ctl");

    // R4 divisor latch
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R4 divisor low"); chk_irq(1'b0, "R4 no pop interrupt");
    rd(3'd1, 8'h12, "R4 divisor high");
    wr(3'd0, 8'h41);
    rd(3'd0, 8'h75, "R4 divisor OR");
    rd(3'd5, 8'h60, "R4 no push");
    wr(3'd3, 8'h80);
    rd(3'd0, 8'h00, "R4 divisor cleared low");
    rd(3'd1, 8'h00, "R4 divisor cleared high");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h0A, "R4 enable untouched");
    rd(3'd3, 8'h03, "R13 line ctl back");

    idle(); idle();
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard left %0d reads expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule